// File: doc/BRIEF.md
# Bit-Field and Byte-Order Manipulation Unit

A purely combinational datapath for the integer side of a processor core. In a single evaluation it can shift or rotate an operand, insert a field into a destination, pull a field out, count leading zeros or leading sign bits, mirror the bit order, or swap bytes at three granularities. The result appears at the output in the same cycle the inputs are applied. There is no state and no clock.

A size select picks 64-bit or 32-bit operation. In 32-bit mode the unit reads only the low half of each operand and drives the upper half of the result to zero, so writing the result back behaves like a narrow register write. The shift amount port carries the low bits of a register value. Only the bits that survive reduction modulo the operand size are needed, so an immediate amount and a register amount drive the same port.

Top module: `bfu_top`

## Requirements
- R1: Opcode 0 shifts left and opcode 1 shifts right logically, both with zero fill. The amount is `shamt_i` modulo the operand size (64 when `wide_i`=1, 32 when `wide_i`=0).
- R2: Opcode 2 shifts right arithmetically. The vacated high bits take the copy of the operand's top bit (bit 63 or bit 31). The amount is reduced modulo the operand size.
- R3: Opcode 3 rotates right within the operand size. Bits leaving bit 0 re-enter at the top bit. The amount is reduced modulo the operand size.
- R4: Opcode 4 inserts the low `width_i` bits of `src_a_i` into `src_b_i` starting at bit `lsb_i`, and keeps every other bit of `src_b_i`. With `src_a_i` zero, the field is cleared.
- R5: Opcode 5 extracts `width_i` bits of `src_a_i` starting at bit `lsb_i` and right-aligns them with zero fill above.
- R6: Opcode 6 returns the number of leading zero bits within the operand size. An all-zero operand returns the size.
- R7: Opcode 7 returns the number of bits below the top bit that equal the top bit. An all-zero or all-ones operand returns the size minus 1.
- R8: Opcode 8 reverses the bit order within the operand size, so that bit i moves to bit size-1-i.
- R9: Opcode 9 reverses the byte order within the operand size. Opcode 10 swaps the two bytes inside every 16-bit half-word.
- R10: Opcode 11 reverses the byte order inside each 32-bit word in 64-bit mode. In 32-bit mode it is not permitted and returns zero.
- R11: In 32-bit mode, `src_a_i` and `src_b_i` bits 63:32 have no effect, and result bits 63:32 are zero.
- R12: Opcodes 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see requirements) |
| wide_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| src_a_i | input | 64 | Value operand: shifted, counted, reversed, or the field source |
| src_b_i | input | 64 | Destination operand for field insert |
| shamt_i | input | 6 | Low bits of the shift amount (immediate or register value) |
| lsb_i | input | 6 | Lowest bit position of the field |
| width_i | input | 7 | Field width in bits, 1 to the operand size |
| result_o | output | 64 | Operation result, zero-extended in 32-bit mode |

## Verification
The field checks assume a legal field: `lsb_i` plus `width_i` no larger than the operand size and `width_i` at least 1. The insert, extract and narrow-result properties are therefore enabled only when that holds. The stimulus never leaves this region. Random fields draw the width first and then an lsb from the positions still free above it. The directed fields are chosen inside the same bound, including fields that touch bit 0 and the top bit. All other opcodes accept any operand, and each shift amount is taken from the full 6-bit range, so the modulo-32 reduction is exercised in narrow mode.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [3:0] {
    OP_LSL   = 4'd0,
    OP_LSR   = 4'd1,
    OP_ASR   = 4'd2,
    OP_ROR   = 4'd3,
    OP_BFI   = 4'd4,
    OP_UBFX  = 4'd5,
    OP_CLZ   = 4'd6,
    OP_CLS   = 4'd7,
    OP_RBIT  = 4'd8,
    OP_REV   = 4'd9,
    OP_REV16 = 4'd10,
    OP_REV32 = 4'd11
  } bfu_op_e;
endpackage

// File: rtl/bfu_shift.sv
module bfu_shift import bfu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  bfu_op_e                   op,
  input  logic                      wide,
  input  logic [XLEN-1:0]           opnd,
  input  logic [$clog2(XLEN)-1:0]   amt_raw,
  output logic [XLEN-1:0]           res
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [SHW-1:0] amt;
  assign amt = wide ? amt_raw : {1'b0, amt_raw[SHW-2:0]};

  function automatic logic [XLEN-1:0] do_lsl(input logic [XLEN-1:0] v,
                                             input logic [SHW-1:0] k, input logic full);
    logic [XLEN-1:0] t;
    t = v << k;
    if (!full) t[XLEN-1:HALF] = '0;
    return t;
  endfunction

  function automatic logic [XLEN-1:0] do_asr(input logic [XLEN-1:0] v,
                                             input logic [SHW-1:0] k, input logic full);
    logic [XLEN-1:0] sx, t;
    sx = full ? v : {{HALF{v[HALF-1]}}, v[HALF-1:0]};
    t  = $signed(sx) >>> k;
    if (!full) t[XLEN-1:HALF] = '0;
    return t;
  endfunction

  function automatic logic [XLEN-1:0] do_ror(input logic [XLEN-1:0] v,
                                             input logic [SHW-1:0] k, input logic full);
    logic [2*XLEN-1:0] dw;
    logic [XLEN-1:0]   dn;
    dw = {v, v} >> k;
    dn = {v[HALF-1:0], v[HALF-1:0]} >> k;
    return full ? dw[XLEN-1:0] : {{HALF{1'b0}}, dn[HALF-1:0]};
  endfunction

  always_comb begin
    unique case (op)
      OP_LSL:  res = do_lsl(opnd, amt, wide);
      OP_LSR:  res = opnd >> amt;
      OP_ASR:  res = do_asr(opnd, amt, wide);
      OP_ROR:  res = do_ror(opnd, amt, wide);
      default: res = '0;
    endcase
  end

  // A rotation only moves bits, never creates or drops them
  always_comb begin
    if (op == OP_ROR)
      assert_rotate_keeps_ones_R3: assert ($countones(res) == $countones(opnd));
  end
endmodule

// File: rtl/bfu_field.sv
module bfu_field import bfu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  bfu_op_e                   op,
  input  logic                      legal,
  input  logic [XLEN-1:0]           src,
  input  logic [XLEN-1:0]           dst,
  input  logic [$clog2(XLEN)-1:0]   lsb,
  input  logic [$clog2(XLEN):0]     width,
  output logic [XLEN-1:0]           res
);
  function automatic logic [XLEN-1:0] low_mask(input logic [$clog2(XLEN):0] w);
    return ~({XLEN{1'b1}} << w);
  endfunction

  logic [XLEN-1:0] fmask, place;
  assign fmask = low_mask(width);
  assign place = fmask << lsb;

  always_comb begin
    unique case (op)
      OP_BFI:  res = (dst & ~place) | ((src & fmask) << lsb);
      OP_UBFX: res = (src >> lsb) & fmask;
      default: res = '0;
    endcase
  end

  // Read back the inserted field and compare it with the source bits
  always_comb begin
    if (op == OP_BFI && legal)
      assert_insert_field_R4: assert (((res >> lsb) & fmask) == (src & fmask));
    if (op == OP_UBFX && legal)
      assert_extract_zero_fill_R5: assert ((res >> width) == '0 || width >= XLEN);
  end
endmodule

// File: rtl/bfu_count.sv
module bfu_count import bfu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  bfu_op_e                   op,
  input  logic                      wide,
  input  logic [XLEN-1:0]           opnd,
  output logic [$clog2(XLEN):0]     cnt
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  function automatic logic [SHW:0] lead_zero(input logic [XLEN-1:0] v, input int len);
    logic         hit;
    logic [SHW:0] c;
    hit = 1'b0;
    c   = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (i < len && !hit) begin
        if (v[i]) hit = 1'b1;
        else c++;
      end
    end
    return c;
  endfunction

  int size;
  logic [XLEN-1:0] diff;
  assign size = wide ? XLEN : HALF;
  // bit i is set where bit i and bit i+1 differ
  assign diff = opnd ^ (opnd >> 1);

  always_comb begin
    unique case (op)
      OP_CLZ:  cnt = lead_zero(opnd, size);
      OP_CLS:  cnt = lead_zero(diff, size - 1);
      default: cnt = '0;
    endcase
  end

  always_comb begin
    if (op == OP_CLZ)
      assert_clz_bound_R6: assert (int'(cnt) <= size);
    if (op == OP_CLS)
      assert_cls_bound_R7: assert (int'(cnt) <= size - 1);
  end
endmodule

// File: rtl/bfu_reverse.sv
module bfu_reverse import bfu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  bfu_op_e          op,
  input  logic             wide,
  input  logic [XLEN-1:0]  opnd,
  output logic [XLEN-1:0]  res
);
  localparam int HALF = XLEN / 2;
  localparam int NB   = XLEN / 8;

  logic [XLEN-1:0] rbit_w, rbit_n, byte_w, byte_n, swap16, swap32;

  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_rbit_w
      assign rbit_w[g] = opnd[XLEN-1-g];
    end
    for (g = 0; g < HALF; g++) begin : g_rbit_n
      assign rbit_n[g] = opnd[HALF-1-g];
    end
    for (g = 0; g < NB; g++) begin : g_bytes
      assign byte_w[8*g +: 8] = opnd[8*(NB-1-g) +: 8];
      assign swap16[8*g +: 8] = opnd[8*(g ^ 1) +: 8];
      assign swap32[8*g +: 8] = opnd[8*(g ^ 3) +: 8];
    end
    for (g = 0; g < NB / 2; g++) begin : g_bytes_n
      assign byte_n[8*g +: 8] = opnd[8*(NB/2-1-g) +: 8];
    end
  endgenerate
  assign rbit_n[XLEN-1:HALF] = '0;
  assign byte_n[XLEN-1:HALF] = '0;

  always_comb begin
    unique case (op)
      OP_RBIT:  res = wide ? rbit_w : rbit_n;
      OP_REV:   res = wide ? byte_w : byte_n;
      OP_REV16: res = swap16;
      OP_REV32: res = wide ? swap32 : '0;
      default:  res = '0;
    endcase
  end

  // Permutations keep the population count
  always_comb begin
    if (op == OP_RBIT)
      assert_rbit_ones_R8: assert ($countones(res) == $countones(opnd));
    if (op == OP_REV || op == OP_REV16)
      assert_rev_ones_R9: assert ($countones(res) == $countones(opnd));
    if (op == OP_REV32 && !wide)
      assert_rev32_narrow_R10: assert (res == '0);
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top import bfu_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [3:0]              op_i,
  input  logic                    wide_i,
  input  logic [XLEN-1:0]         src_a_i,
  input  logic [XLEN-1:0]         src_b_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic [$clog2(XLEN)-1:0] lsb_i,
  input  logic [$clog2(XLEN):0]   width_i,
  output logic [XLEN-1:0]         result_o
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  bfu_op_e op;
  assign op = bfu_op_e'(op_i);

  // operands restricted to the active size
  logic [XLEN-1:0] opnd_a, opnd_b;
  assign opnd_a = wide_i ? src_a_i : {{HALF{1'b0}}, src_a_i[HALF-1:0]};
  assign opnd_b = wide_i ? src_b_i : {{HALF{1'b0}}, src_b_i[HALF-1:0]};

  // named event: field lies inside the operand
  logic field_legal;
  assign field_legal = (int'(lsb_i) + int'(width_i)) <= (wide_i ? XLEN : HALF);

  logic [XLEN-1:0] shift_res, field_res, rev_res;
  logic [SHW:0]    cnt_res;

  bfu_shift #(.XLEN(XLEN)) u_shift (
    .op(op), .wide(wide_i), .opnd(opnd_a), .amt_raw(shamt_i), .res(shift_res)
  );
  bfu_field #(.XLEN(XLEN)) u_field (
    .op(op), .legal(field_legal), .src(opnd_a), .dst(opnd_b),
    .lsb(lsb_i), .width(width_i), .res(field_res)
  );
  bfu_count #(.XLEN(XLEN)) u_count (
    .op(op), .wide(wide_i), .opnd(opnd_a), .cnt(cnt_res)
  );
  bfu_reverse #(.XLEN(XLEN)) u_reverse (
    .op(op), .wide(wide_i), .opnd(opnd_a), .res(rev_res)
  );

  always_comb begin
    case (op)
      OP_LSL, OP_LSR, OP_ASR, OP_ROR:      result_o = shift_res;
      OP_BFI, OP_UBFX:                     result_o = field_res;
      OP_CLZ, OP_CLS:                      result_o = {{(XLEN-SHW-1){1'b0}}, cnt_res};
      OP_RBIT, OP_REV, OP_REV16, OP_REV32: result_o = rev_res;
      default:                             result_o = '0;
    endcase
  end

  always_comb begin
    if (!wide_i && field_legal)
      assert_narrow_upper_zero_R11: assert (result_o[XLEN-1:HALF] == '0);
    if (op_i >= 4'd12)
      assert_unused_op_zero_R12: assert (result_o == '0);
  end
endmodule

// File: tb/sim_bfu_top.sv
module sim_bfu_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]  op;
  logic        wide;
  logic [63:0] a, b;
  logic [5:0]  sh, lsb;
  logic [6:0]  wd;
  logic [63:0] res;

  bfu_top u0 (
    .op_i(op), .wide_i(wide), .src_a_i(a), .src_b_i(b), .shamt_i(sh),
    .lsb_i(lsb), .width_i(wd), .result_o(res)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  string       req_q[$];

  // independent reference, bit by bit
  function automatic logic [63:0] model(input int o, input bit w, input logic [63:0] x,
                                        input logic [63:0] y, input int s, input int l,
                                        input int fw);
    int n, k, c;
    logic [63:0] xm, r;
    n = w ? 64 : 32;
    k = s % n;
    r = '0;
    for (int i = 0; i < 64; i++) xm[i] = (i < n) ? x[i] : 1'b0;
    case (o)
      0: for (int i = 0; i < n; i++) if (i >= k) r[i] = xm[i-k];
      1: for (int i = 0; i < n; i++) if (i + k < n) r[i] = xm[i+k];
      2: for (int i = 0; i < n; i++) r[i] = (i + k < n) ? xm[i+k] : xm[n-1];
      3: for (int i = 0; i < n; i++) r[i] = xm[(i+k) % n];
      4: begin
        for (int i = 0; i < n; i++) r[i] = y[i];
        for (int i = 0; i < fw; i++) r[l+i] = xm[i];
      end
      5: for (int i = 0; i < fw; i++) r[i] = xm[l+i];
      6: begin
        c = 0;
        for (int i = n - 1; i >= 0 && xm[i] == 1'b0; i--) c++;
        r = 64'(c);
      end
      7: begin
        c = 0;
        for (int i = n - 2; i >= 0 && xm[i] == xm[n-1]; i--) c++;
        r = 64'(c);
      end
      8: for (int i = 0; i < n; i++) r[i] = xm[n-1-i];
      9: for (int j = 0; j < n / 8; j++) r[8*j +: 8] = xm[8*(n/8-1-j) +: 8];
      10: for (int j = 0; j < n / 8; j++) r[8*j +: 8] = xm[8*(j ^ 1) +: 8];
      11: if (w) for (int j = 0; j < 8; j++) r[8*j +: 8] = xm[8*(j ^ 3) +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input int o);
    case (o)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9, 10: return "R9";
      11: return "R10";
      default: return "R12";
    endcase
  endfunction

  // driver: apply stimulus just after the edge and post the expectation
  task automatic drive(input int o, input bit w, input logic [63:0] x, input logic [63:0] y,
                       input int s, input int l, input int fw, input string rq);
    @(posedge clk);
    #1;
    op = 4'(o); wide = w; a = x; b = y; sh = 6'(s); lsb = 6'(l); wd = 7'(fw);
    exp_q.push_back(model(o, w, x, y, s, l, fw));
    req_q.push_back(rq);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        total++;
        if (res !== e) begin
          bad++;
          $display("FAIL %s: got %h expected %h (op=%0d wide=%0d)", rq, res, e, op, wide);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] P = 64'h0123_4567_89ab_cdef;
  localparam logic [63:0] Q = 64'hf0e1_d2c3_b4a5_9687;

  initial begin
    logic [63:0] rs;
    op = 4'd15; wide = 1'b1; a = '0; b = '0; sh = '0; lsb = '0; wd = 7'd1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset / idle state: unused opcode gives zero (R12)
    drive(15, 1, '0, '0, 0, 0, 1, "R12");
    drive(12, 1, P, Q, 5, 3, 4, "R12");
    // R1 shifts, modulo amount in narrow mode (40 -> 8)
    drive(0, 1, P, 0, 12, 0, 1, "R1");
    drive(1, 1, Q, 0, 63, 0, 1, "R1");
    drive(0, 0, P, 0, 40, 0, 1, "R1");
    drive(1, 0, Q, 0, 33, 0, 1, "R1");
    // R2 arithmetic right
    drive(2, 1, Q, 0, 20, 0, 1, "R2");
    drive(2, 0, 64'h0000_0000_8000_0001, 0, 31, 0, 1, "R2");
    drive(2, 0, 64'hffff_ffff_7fff_0000, 0, 4, 0, 1, "R2");
    // R3 rotate, including amount 0
    drive(3, 1, P, 0, 4, 0, 1, "R3");
    drive(3, 0, P, 0, 36, 0, 1, "R3");
    drive(3, 1, Q, 0, 0, 0, 1, "R3");
    // R4 insert, full width and zero-source clear
    drive(4, 1, 64'h3f, 64'h0, 9, 9, 6, "R4");
    drive(4, 0, 64'h0, 64'hffff_ffff_ffff_ffff, 0, 3, 4, "R4");
    drive(4, 1, Q, P, 0, 0, 64, "R4");
    drive(4, 0, Q, P, 0, 31, 1, "R4");
    // R5 extract at the top edge and full width
    drive(5, 1, P, 0, 0, 18, 7, "R5");
    drive(5, 0, Q, 0, 0, 0, 32, "R5");
    drive(5, 1, Q, 0, 0, 60, 4, "R5");
    // R6 / R7 counts, extremes
    drive(6, 1, 0, 0, 0, 0, 1, "R6");
    drive(6, 0, 64'hffff_ffff_0000_0000, 0, 0, 0, 1, "R6");
    drive(6, 1, 64'h0000_0100_0000_0000, 0, 0, 0, 1, "R6");
    drive(7, 1, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 1, "R7");
    drive(7, 0, 0, 0, 0, 0, 1, "R7");
    drive(7, 0, 64'h0000_0000_fff0_0000, 0, 0, 0, 1, "R7");
    // R8 .. R10 reversals
    drive(8, 1, P, 0, 0, 0, 1, "R8");
    drive(8, 0, P, 0, 0, 0, 1, "R8");
    drive(9, 1, P, 0, 0, 0, 1, "R9");
    drive(9, 0, P, 0, 0, 0, 1, "R9");
    drive(10, 1, P, 0, 0, 0, 1, "R9");
    drive(11, 1, P, 0, 0, 0, 1, "R10");
    drive(11, 0, P, 0, 0, 0, 1, "R10");
    // R11: upper operand bits ignored in narrow mode
    drive(0, 0, 64'hdead_beef_0000_0001, 0, 3, 0, 1, "R11");
    drive(4, 0, 64'hffff_ffff_0000_000f, 64'haaaa_aaaa_0000_0000, 0, 8, 4, "R11");
    drive(6, 0, 64'hffff_ffff_0000_0001, 0, 0, 0, 1, "R11");
    // random sweep inside legal field ranges
    rs = 64'h9e37_79b9_7f4a_7c15;
    for (int it = 0; it < 400; it++) begin
      int o, sz, fw, l;
      bit w;
      logic [63:0] x, y;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
      x = rs;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
      y = rs;
      o  = int'(y[3:0]);
      w  = y[4];
      sz = w ? 64 : 32;
      fw = 1 + int'(y[15:8]) % sz;
      l  = int'(y[31:24]) % (sz - fw + 1);
      drive(o, w, x, ~y, int'(y[45:40]), l, fw, req_of(o));
    end
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule